// File: doc/BRIEF.md
# Extended Match-Timer Channel Bank

This block holds eight match-timer channels, numbered 4 to 11, behind a small register port. Each channel has a counter, a match value and a control word. The control word picks one of five tick-enable strobes (or none) as the count rate. It also decides whether the channel compares against its own counter or against a counter it shares with a group leader. Further control bits set reset-on-match, periodic or single matching, and, on two channels, capture of the paired leader's counter into a snapshot register whenever that channel's counter is read.

A match that meets an enabled interrupt bit sets a sticky status bit. One combined interrupt output is high while any status bit is set, and software clears status bits by writing ones. The strobes come from a prescaler outside this block. Each strobe is one cycle wide, and a counter advances once per cycle in which its selected strobe is high.

Register map (byte offsets, 4-byte stride, channel k = 4..11, slot s = k-4): counter at 0x40+4s, match at 0x80+4s, control at 0xC0+4s, status at 0x14, interrupt enable at 0x1C, snapshot at 0x20. Status and enable keep channel k in bit k. Reads of any other offset return 0.

Top module: `ext_tmr`

## Requirements
- R1: Counter, match and control registers of every channel are written and read back at their own offsets. Control words of channels 4–7 keep bits [7:0] only, and those of channels 8–11 keep bits [9:0]. Unmapped offsets read 0.
- R2: Control bits [2:0] choose the rate. Code 1 selects ticks[0], code 2 ticks[1], code 3 ticks[2], code 4 ticks[3] and code 5 ticks[4]. Codes 0, 6 and 7 stop the counter, which then holds its value.
- R3: On channels 8–11, control bit 8 stops the counter whatever code bits [2:0] hold. On channels 4–7, that bit is not stored and has no effect.
- R4: Writing a counter loads it, and the write takes priority over a tick in the same cycle. Otherwise a counter moves by at most one step per cycle.
- R5: Channels 4, 8 and 10 always count at their selected rate. When control bit 7 is clear, channels 5–7 match against channel 4's counter, channel 9 against channel 8's, and channel 11 against channel 10's. In that case the channel's own counter holds, and its own rate code is ignored. With bit 7 set, a channel counts and matches on its own counter.
- R6: A match happens in the cycle in which the compared counter steps onto the match value. It sets status bit k only if enable bit k is set. Writing a one to a status bit clears it, and a match in the same cycle wins over the clear.
- R7: The interrupt output is high exactly while any status bit 4–11 is set.
- R8: With control bit 3 set on a channel that uses its own counter, the step that matches loads 0 into the counter instead of the match value.
- R9: With control bit 6 set, a channel matches every time. With it clear, the channel matches once and then stays quiet until its match or counter register is written.
- R10: Reading channel 9's or 11's counter while that channel's control bit 9 is set copies channel 8's or 10's counter into the snapshot register. With bit 9 clear, such a read leaves the snapshot unchanged.
- R11: After reset, all counters, match values, control words, status, enables and the snapshot are 0, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ticks | input | 5 | Tick-enable strobes, rate codes 1..5 map to bits 0..4 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (snapshot side effect) |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq | output | 1 | Combined interrupt of channels 4–11 |

## Verification
The rate selection is swept over every channel, every code 0–7 and both settings of control bit 8. Each strobe is pulsed for a different number of cycles, so the final count names exactly which strobe drove the counter, or shows that none did. The match tests then compare a leader and its followers, reset-on-match against free running, and periodic against single matching. Each pairing is chosen so that a wrong choice leaves a different counter value or status word. The snapshot tests read the paired counters with the capture bit both set and clear, and compare the captured value.

// File: rtl/ext_tmr_pkg.sv
package ext_tmr_pkg;
  localparam int NCH = 8;

  typedef enum logic [1:0] {K_NONE, K_CNT, K_MATCH, K_CTRL} kind_t;

  // strobe chosen by a rate code; 0, 6 and 7 mean stopped
  function automatic logic tick_pick(input logic [2:0] code, input logic [4:0] t);
    case (code)
      3'd1: return t[0];
      3'd2: return t[1];
      3'd3: return t[2];
      3'd4: return t[3];
      3'd5: return t[4];
      default: return 1'b0;
    endcase
  endfunction

  // slot whose counter a slot shares when it does not run its own
  function automatic int leader_of(input int s);
    return (s < 4) ? 0 : (s & ~1);
  endfunction

  function automatic bit is_leader(input int s);
    return leader_of(s) == s;
  endfunction

  function automatic logic [9:0] ctrl_keep(input int s);
    return (s < 4) ? 10'h0FF : 10'h3FF;
  endfunction
endpackage

// File: rtl/ext_tmr_dec.sv
module ext_tmr_dec
  import ext_tmr_pkg::*;
(
  input  logic [7:0] addr,
  output kind_t      kind,
  output logic [2:0] idx,
  output logic       sel_stat,
  output logic       sel_ien,
  output logic       sel_snap
);
  logic aligned;
  assign aligned  = (addr[1:0] == 2'b00);
  assign idx      = addr[4:2];
  assign sel_stat = (addr == 8'h14);
  assign sel_ien  = (addr == 8'h1C);
  assign sel_snap = (addr == 8'h20);

  always_comb begin
    kind = K_NONE;
    if (aligned && !addr[5]) begin
      case (addr[7:6])
        2'b01:   kind = K_CNT;
        2'b10:   kind = K_MATCH;
        2'b11:   kind = K_CTRL;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ext_tmr_chan.sv
module ext_tmr_chan
  import ext_tmr_pkg::*;
#(
  parameter int SLOT = 0,
  parameter int CW   = 32,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    ticks,
  input  logic          wr_ctrl,
  input  logic          wr_match,
  input  logic          wr_cnt,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] lead_cnt,
  input  logic          lead_adv,
  output logic [9:0]    ctrl_q,
  output logic [CW-1:0] match_q,
  output logic [CW-1:0] cnt_q,
  output logic          adv,
  output logic          hit
);
  localparam bit         LEADER = is_leader(SLOT);
  localparam logic [9:0] KEEP   = ctrl_keep(SLOT);

  logic          armed;
  logic          own_run;
  logic [CW-1:0] eff_cnt;
  logic          eff_adv;

  assign own_run = LEADER || ctrl_q[7];
  assign adv     = own_run && !ctrl_q[8] && tick_pick(ctrl_q[2:0], ticks) && !wr_cnt;
  assign eff_cnt = own_run ? cnt_q : lead_cnt;
  assign eff_adv = own_run ? adv : lead_adv;
  assign hit     = armed && eff_adv && ((eff_cnt + CW'(1)) == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      match_q <= '0;
      cnt_q   <= '0;
      armed   <= 1'b1;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wdata[9:0] & KEEP;
      if (wr_match) match_q <= wdata[CW-1:0];
      if (wr_cnt)                          cnt_q <= wdata[CW-1:0];
      else if (hit && ctrl_q[3] && own_run) cnt_q <= '0;
      else if (adv)                        cnt_q <= cnt_q + CW'(1);
      if (wr_match || wr_cnt)      armed <= 1'b1;
      else if (hit && !ctrl_q[6])  armed <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_tmr.sv
module ext_tmr
  import ext_tmr_pkg::*;
#(
  parameter int CW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    ticks,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int SB = 4;  // status bit of slot 0

  kind_t      kind;
  logic [2:0] idx;
  logic       sel_stat, sel_ien, sel_snap;

  logic [NCH-1:0][CW-1:0] cnt_v, match_v;
  logic [NCH-1:0][9:0]    ctrl_v;
  logic [NCH-1:0]         adv_v, hit_v, wr_cnt_v, wr_match_v, wr_ctrl_v;
  logic [NCH-1:0]         stat_q, ien_q;
  logic [DW-1:0]          snap_q;
  logic                   wr_stat, snap_take;

  ext_tmr_dec u_dec (
    .addr(bus_addr), .kind(kind), .idx(idx),
    .sel_stat(sel_stat), .sel_ien(sel_ien), .sel_snap(sel_snap)
  );

  for (genvar s = 0; s < NCH; s++) begin : g_ch
    localparam int L = leader_of(s);
    assign wr_cnt_v[s]   = bus_wr && (kind == K_CNT)   && (idx == 3'(s));
    assign wr_match_v[s] = bus_wr && (kind == K_MATCH) && (idx == 3'(s));
    assign wr_ctrl_v[s]  = bus_wr && (kind == K_CTRL)  && (idx == 3'(s));

    ext_tmr_chan #(.SLOT(s), .CW(CW), .DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .ticks(ticks),
      .wr_ctrl(wr_ctrl_v[s]), .wr_match(wr_match_v[s]), .wr_cnt(wr_cnt_v[s]),
      .wdata(bus_wdata), .lead_cnt(cnt_v[L]), .lead_adv(adv_v[L]),
      .ctrl_q(ctrl_v[s]), .match_q(match_v[s]), .cnt_q(cnt_v[s]),
      .adv(adv_v[s]), .hit(hit_v[s])
    );
  end

  assign wr_stat   = bus_wr && sel_stat;
  assign snap_take = bus_rd && (kind == K_CNT) && (idx == 3'd5 || idx == 3'd7)
                     && ctrl_v[idx][9];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
      snap_q <= '0;
    end else begin
      stat_q <= (stat_q & ~(wr_stat ? bus_wdata[SB+NCH-1:SB] : '0)) | (hit_v & ien_q);
      if (bus_wr && sel_ien) ien_q <= bus_wdata[SB+NCH-1:SB];
      if (snap_take) snap_q <= DW'(cnt_v[idx - 3'd1]);
    end
  end

  assign irq = |stat_q;

  always_comb begin
    bus_rdata = '0;
    case (kind)
      K_CNT:   bus_rdata = DW'(cnt_v[idx]);
      K_MATCH: bus_rdata = DW'(match_v[idx]);
      K_CTRL:  bus_rdata = DW'(ctrl_v[idx]);
      default: begin
        if (sel_stat)      bus_rdata = DW'({stat_q, 4'b0000});
        else if (sel_ien)  bus_rdata = DW'({ien_q, 4'b0000});
        else if (sel_snap) bus_rdata = snap_q;
      end
    endcase
  end
endmodule

// File: rtl/ext_tmr_chk.sv
module ext_tmr_chk #(
  parameter int CW = 32,
  parameter int DW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           hit_v,
  input logic [7:0]           stat_q,
  input logic [7:0]           ien_q,
  input logic                 irq,
  input logic                 wr_stat,
  input logic                 bus_rd,
  input logic [DW-1:0]        snap_q,
  input logic [7:0][CW-1:0]   cnt_v,
  input logic [7:0][9:0]      ctrl_v,
  input logic [7:0]           wr_cnt_v,
  input logic [7:0]           wr_match_v
);
  AST_IRQ_RISE_FROM_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(hit_v & ien_q))); // R7

  AST_IRQ_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_stat)); // R7

  AST_SNAP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_q) |-> $past(bus_rd)); // R10

  for (genvar k = 0; k < 8; k++) begin : g_k
    AST_STAT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[k]) |-> $past(hit_v[k] && ien_q[k])); // R6

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_v[k][2:0] == 3'd0 && !wr_cnt_v[k]) |=> $stable(cnt_v[k])); // R2

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt_v[k] |=> (cnt_v[k] == $past(cnt_v[k]) || cnt_v[k] == $past(cnt_v[k]) + CW'(1)
                        || cnt_v[k] == '0)); // R4

    AST_ONESHOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_v[k] && !ctrl_v[k][6] && !wr_cnt_v[k] && !wr_match_v[k]) |=> !hit_v[k]); // R9
  end
endmodule

bind ext_tmr ext_tmr_chk #(.CW(CW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_v(hit_v), .stat_q(stat_q), .ien_q(ien_q),
  .irq(irq), .wr_stat(wr_stat), .bus_rd(bus_rd), .snap_q(snap_q),
  .cnt_v(cnt_v), .ctrl_v(ctrl_v), .wr_cnt_v(wr_cnt_v), .wr_match_v(wr_match_v)
);

// File: tb/test_ext_tmr.sv
module test_ext_tmr;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ticks = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int fails = 0;

  ext_tmr i_ext_tmr (
    .clk(clk), .rst_n(rst_n), .ticks(ticks), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] a_cnt(input int s);   return 8'(8'h40 + 4*s); endfunction
  function automatic logic [7:0] a_match(input int s); return 8'(8'h80 + 4*s); endfunction
  function automatic logic [7:0] a_ctrl(input int s);  return 8'(8'hC0 + 4*s); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m, input int n);
    for (int i = 0; i < n; i++) begin
      ticks = m;
      @(posedge clk); @(negedge clk);
    end
    ticks = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd_chk("R11 cnt4", a_cnt(0), 0);
    rd_chk("R11 match7", a_match(3), 0);
    rd_chk("R11 ctrl11", a_ctrl(7), 0);
    rd_chk("R11 status", 8'h14, 0);
    rd_chk("R11 enable", 8'h1C, 0);
    rd_chk("R11 snapshot", 8'h20, 0);
    check("R11 irq", 32'(irq), 0);

    // R1 distinct read-back at each offset; unmapped reads 0
    for (int s = 0; s < 8; s++) wr(a_match(s), 32'hA000 + 32'(s));
    for (int s = 0; s < 8; s++) rd_chk("R1 match", a_match(s), 32'hA000 + 32'(s));
    rd_chk("R1 unmapped", 8'h24, 0);

    // R2 R3 R1: sweep every channel, every code, bit 8 on/off
    for (int s = 0; s < 8; s++) begin
      for (int code = 0; code < 8; code++) begin
        for (int b8 = 0; b8 < 2; b8++) begin
          logic [31:0] cw;
          int exp;
          cw = 32'h80 | 32'(code) | (b8 != 0 ? 32'h300 : 32'h0);
          wr(a_ctrl(s), cw);
          wr(a_cnt(s), 0);
          for (int k = 0; k < 5; k++) pulse(5'(1 << k), k + 1);
          exp = (code >= 1 && code <= 5 && !(b8 != 0 && s >= 4)) ? code : 0;
          rd_chk((b8 != 0 && s >= 4) ? "R3 forced stop" : "R2 rate select", a_cnt(s), 32'(exp));
          rd_chk("R1 ctrl mask", a_ctrl(s), (s < 4) ? (cw & 32'hFF) : cw);
          wr(a_ctrl(s), 0);
        end
      end
    end

    // R5 sharing: slot1 (ch5) follows slot0 (ch4)
    wr(a_ctrl(0), 1);          // leader, bit 7 clear, still runs
    wr(a_ctrl(1), 1);          // follower
    wr(a_match(1), 3);
    wr(8'h1C, 32'h20);
    wr(a_cnt(0), 0);
    wr(a_cnt(1), 0);
    pulse(5'b00001, 3);
    rd_chk("R5 leader counts", a_cnt(0), 3);
    rd_chk("R5 follower own held", a_cnt(1), 0);
    rd_chk("R6 status from shared match", 8'h14, 32'h20);
    check("R7 irq high", 32'(irq), 1);
    wr(8'h14, 32'h20);
    rd_chk("R6 w1c", 8'h14, 0);
    check("R7 irq low", 32'(irq), 0);
    // R6 enable gating
    wr(8'h1C, 0);
    wr(a_match(1), 5);
    pulse(5'b00001, 2);
    rd_chk("R6 disabled no status", 8'h14, 0);
    check("R7 irq stays low", 32'(irq), 0);
    wr(a_ctrl(0), 0);
    wr(a_ctrl(1), 0);

    // R5 ch11 follows ch10, own code 0 ignored
    wr(a_ctrl(6), 4);
    wr(a_ctrl(7), 0);
    wr(a_match(7), 2);
    wr(8'h1C, 32'h800);
    wr(a_cnt(6), 0);
    pulse(5'b01000, 2);
    rd_chk("R5 ch11 via ch10", 8'h14, 32'h800);
    wr(8'h14, 32'h800);
    wr(a_ctrl(6), 0);

    // R8 R9 on slot2 (ch6), status bit 6
    wr(8'h1C, 32'h40);
    wr(a_ctrl(2), 32'hC9);     // own, periodic, reset-on-match, code 1
    wr(a_match(2), 4);
    wr(a_cnt(2), 0);
    pulse(5'b00001, 4);
    rd_chk("R8 cleared on match", a_cnt(2), 0);
    rd_chk("R6 status ch6", 8'h14, 32'h40);
    wr(8'h14, 32'h40);
    pulse(5'b00001, 4);
    rd_chk("R9 periodic rematch", 8'h14, 32'h40);
    wr(8'h14, 32'h40);
    wr(a_ctrl(2), 32'h89);     // single match
    wr(a_cnt(2), 0);
    pulse(5'b00001, 4);
    rd_chk("R9 single first", 8'h14, 32'h40);
    wr(8'h14, 32'h40);
    pulse(5'b00001, 4);
    rd_chk("R9 single quiet status", 8'h14, 0);
    rd_chk("R9 single quiet count", a_cnt(2), 4);
    wr(a_match(2), 6);         // rearm
    pulse(5'b00001, 2);
    rd_chk("R9 rearm by match write", 8'h14, 32'h40);
    rd_chk("R8 cleared after rearm", a_cnt(2), 0);
    wr(8'h14, 32'h40);
    wr(a_ctrl(2), 32'hC1);     // periodic, no reset
    wr(a_match(2), 2);
    wr(a_cnt(2), 0);
    pulse(5'b00001, 3);
    rd_chk("R8 no reset keeps counting", a_cnt(2), 3);
    rd_chk("R6 status no-reset", 8'h14, 32'h40);
    wr(8'h14, 32'h40);
    wr(a_ctrl(2), 0);

    // R4 write wins over tick
    wr(a_ctrl(3), 32'h81);
    bus_addr = a_cnt(3); bus_wdata = 32'h77; bus_wr = 1'b1; ticks = 5'b00001;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; ticks = '0;
    rd_chk("R4 write over tick", a_cnt(3), 32'h77);
    wr(a_ctrl(3), 0);

    // R10 snapshot
    wr(a_cnt(4), 32'h1234);
    wr(a_ctrl(5), 32'h200);
    rd_chk("R10 ch9 own count", a_cnt(5), 0);
    rd_chk("R10 snap ch8", 8'h20, 32'h1234);
    wr(a_cnt(6), 32'h55);
    wr(a_ctrl(7), 0);
    rd_chk("R10 ch11 own count", a_cnt(7), 0);
    rd_chk("R10 no capture bit clear", 8'h20, 32'h1234);
    wr(a_ctrl(7), 32'h200);
    rd_chk("R10 ch11 read", a_cnt(7), 0);
    rd_chk("R10 snap ch10", 8'h20, 32'h55);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule